// File: doc/BRIEF.md
# Indirect Pointer Load Unit

This block carries out the byte loads of an 8-bit RISC core that take their address from a 16-bit pointer. The pointer is held in two entries of the core's 32-entry register file. Entry 27 holds the high byte and entry 26 holds the low byte. The unit decodes a 16-bit instruction word and recognises three forms: a plain load, a load followed by a pointer increment, and a pointer decrement followed by a load. It presents the effective address on a data-space read port and writes the returned byte into the destination register. When the form calls for it, the unit also writes the updated pointer back.

Each form occupies a fixed number of cycles. An input selects one of two timing profiles. The first is a longer classic profile. The second is a compact profile that adds one wait cycle when the effective address falls in the internal SRAM window. A fetch stage hands instructions in with a valid strobe and watches `busy` and `done`. The rest of the core can write the register file through a side port while no load is in flight, and can read any entry through a read port.

Top module: `ptr_load_unit`

## Requirements
- R1: A word is accepted only if bits 15:9 equal 1001000 and bits 3:0 equal 1100, 1101 or 1110. Any other word is ignored: busy and done stay low and no register changes.
- R2: Low nibble 1100 reads the byte at pointer {r27,r26} into the register named by bits 8:4. The pointer is left unchanged.
- R3: Low nibble 1101 reads at the current pointer and then sets the pointer to pointer+1 modulo 2^16. The carry passes into r27, so 0xFFFF wraps to 0x0000.
- R4: Low nibble 1110 sets the pointer to pointer-1 modulo 2^16 and reads at that decremented address. The borrow passes into r27, so 0x0000 wraps to 0xFFFF.
- R5: With compact_mode low when the word is accepted, done rises 1, 2 or 3 cycles after the accepting edge for plain, increment and decrement respectively. busy is high in every earlier cycle of the instruction and is never high together with done.
- R6: With compact_mode high when the word is accepted, the counts are 1, 1 and 2 cycles. One cycle is added when the effective address lies in 0x0100..0x40FF inclusive.
- R7: mem_rd_en is high only in the done cycle, and mem_addr then carries the effective address. done lasts one cycle per instruction.
- R8: The destination register and the pointer keep their old values until the done cycle ends. Both are committed at that same clock edge.
- R9: If the destination is r26 or r27 and the form changes the pointer, the loaded byte overwrites that pointer byte. The other pointer byte takes the updated pointer value, and illegal_combo is high during the instruction.
- R10: A word is accepted only while busy is low. A word offered while busy is high is ignored. A word offered in the done cycle is accepted and sees the pointer just committed.
- R11: A side-port register write is ignored while an instruction is in flight (busy or done high). At any other time it is applied at the next edge.
- R12: After reset, busy, done, illegal_combo and mem_rd_en are low and all 32 registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered this cycle |
| instr_word | input | 16 | Instruction word |
| compact_mode | input | 1 | Timing profile, sampled at acceptance: 1 compact, 0 classic |
| busy | output | 1 | Instruction in flight and not in its last cycle |
| done | output | 1 | Last cycle of the instruction |
| illegal_combo | output | 1 | Current instruction loads into a pointer byte it also updates |
| mem_rd_en | output | 1 | Data-space read strobe |
| mem_addr | output | 16 | Data-space read address |
| mem_rd_data | input | 8 | Read data, sampled at the edge closing the strobe cycle |
| rf_wr_en | input | 1 | Side-port register write enable |
| rf_wr_idx | input | 5 | Side-port register index |
| rf_wr_data | input | 8 | Side-port register data |
| rf_rd_idx | input | 5 | Register read index |
| rf_rd_data | output | 8 | Register read data (combinational) |

## Verification
The bench drives the pointer across 0x00FF/0x0100, 0x12FF/0x1300 and both 16-bit wrap points. A unit with a broken carry or borrow chain leaves r27 stale or fails to wrap. A unit whose SRAM test checks the pointer rather than the decremented address gets the compact cycle count wrong by one. Loads into r26 and r27 with increment and decrement show whether the loaded byte wins over the pointer update and whether the flag is raised. Back-to-back issue in the done cycle checks that the second load sees the committed pointer, and words offered while busy must not restart the count. Side-port writes offered during a load must be dropped, and the registers are read mid-instruction to confirm that no early commit takes place.

// File: rtl/ptr_ld_pkg.sv
// ptr_ld_pkg: shared types, opcode constants and the cycle-count rule for
// the indirect pointer load unit. Assumes 16-bit instruction words with a
// 5-bit destination field in bits 8:4.
package ptr_ld_pkg;

    localparam int IDX_W = 5;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_POSTINC = 2'd1,
        MODE_PREDEC  = 2'd2
    } ld_mode_e;

    typedef struct packed {
        logic             hit;
        ld_mode_e         mode;
        logic [IDX_W-1:0] dst;
    } ld_decode_t;

    localparam logic [6:0] OPC_UPPER   = 7'b1001000;
    localparam logic [3:0] NIB_PLAIN   = 4'b1100;
    localparam logic [3:0] NIB_POSTINC = 4'b1101;
    localparam logic [3:0] NIB_PREDEC  = 4'b1110;

    // Base number of cycles for a form in a timing profile, before the SRAM wait.
    function automatic logic [2:0] base_cycles(ld_mode_e m, logic compact);
        logic [2:0] n;
        case (m)
            MODE_PLAIN:   n = 3'd1;
            MODE_POSTINC: n = compact ? 3'd1 : 3'd2;
            MODE_PREDEC:  n = compact ? 3'd2 : 3'd3;
            default:      n = 3'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ptr_ld_decode.sv
// ptr_ld_decode: combinational decoder for the three indirect load forms.
// Assumes nothing about timing; flags a hit only for exact opcode matches.
module ptr_ld_decode
    import ptr_ld_pkg::*;
(
    input  logic [15:0] word_i,
    output ld_decode_t  dec_o
);

    logic upper_ok;

    // Compare the fixed upper opcode bits.
    always_comb upper_ok = (word_i[15:9] == OPC_UPPER);

    // Map the low nibble to an addressing form and extract the destination.
    always_comb begin
        dec_o.dst  = word_i[8:4];
        dec_o.hit  = 1'b0;
        dec_o.mode = MODE_PLAIN;
        case (word_i[3:0])
            NIB_PLAIN: begin
                dec_o.hit  = upper_ok;
                dec_o.mode = MODE_PLAIN;
            end
            NIB_POSTINC: begin
                dec_o.hit  = upper_ok;
                dec_o.mode = MODE_POSTINC;
            end
            NIB_PREDEC: begin
                dec_o.hit  = upper_ok;
                dec_o.mode = MODE_PREDEC;
            end
            default: begin
                dec_o.hit  = 1'b0;
                dec_o.mode = MODE_PLAIN;
            end
        endcase
    end

endmodule

// File: rtl/ptr_ld_addr.sv
// ptr_ld_addr: pointer arithmetic for the load forms. Produces the
// effective address, the pointer value to commit and the SRAM-window hit.
// Assumes arithmetic modulo 2^ADDR_W.
module ptr_ld_addr
    import ptr_ld_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SRAM_LO = 16'h0100,
    parameter logic [ADDR_W-1:0] SRAM_HI = 16'h40FF
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  ld_mode_e          mode_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic [ADDR_W-1:0] next_ptr_o,
    output logic              sram_hit_o
);

    logic [ADDR_W-1:0] ptr_inc;
    logic [ADDR_W-1:0] ptr_dec;

    // Full-width increment and decrement so carry and borrow cross bytes.
    always_comb begin
        ptr_inc = ptr_i + ADDR_W'(1);
        ptr_dec = ptr_i - ADDR_W'(1);
    end

    // Select the address used for the read and the pointer to write back.
    always_comb begin
        case (mode_i)
            MODE_POSTINC: begin
                eff_addr_o = ptr_i;
                next_ptr_o = ptr_inc;
            end
            MODE_PREDEC: begin
                eff_addr_o = ptr_dec;
                next_ptr_o = ptr_dec;
            end
            default: begin
                eff_addr_o = ptr_i;
                next_ptr_o = ptr_i;
            end
        endcase
    end

    // Window test on the effective address, inclusive at both ends.
    always_comb sram_hit_o = (eff_addr_o >= SRAM_LO) && (eff_addr_o <= SRAM_HI);

endmodule

// File: rtl/ptr_ld_seq.sv
// ptr_ld_seq: instruction sequencer. Latches the decoded form and profile
// at acceptance, counts cycles and marks the last one. Assumes the pointer
// (and therefore sram_hit_i) is stable while an instruction is in flight.
module ptr_ld_seq
    import ptr_ld_pkg::*;
#(
    parameter int MAX_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  ld_decode_t       dec_i,
    input  logic             compact_i,
    input  logic             sram_hit_i,
    output logic             active_o,
    output logic             busy_o,
    output logic             done_o,
    output ld_mode_e         mode_o,
    output logic [IDX_W-1:0] dst_o
);

    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] total;
    logic             compact_q;
    logic             last;

    // Cycle budget for the latched form, plus the SRAM wait in compact mode.
    always_comb total = CNT_W'(base_cycles(mode_o, compact_q))
                      + CNT_W'(compact_q & sram_hit_i);

    // Last cycle of the instruction in flight.
    always_comb last = active_o && (cnt_q == total);

    // Handshake outputs derived from the cycle position.
    always_comb begin
        busy_o = active_o && !last;
        done_o = last;
    end

    // Acceptance, cycle counting and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o  <= 1'b0;
            cnt_q     <= CNT_W'(1);
            compact_q <= 1'b0;
            mode_o    <= MODE_PLAIN;
            dst_o     <= '0;
        end else if (start_i) begin
            active_o  <= 1'b1;
            cnt_q     <= CNT_W'(1);
            compact_q <= compact_i;
            mode_o    <= dec_i.mode;
            dst_o     <= dec_i.dst;
        end else if (last) begin
            active_o  <= 1'b0;
        end else if (active_o) begin
            cnt_q     <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ptr_ld_regfile.sv
// ptr_ld_regfile: register file with a pointer pair. Write priority is
// load result, then pointer update, then side port. Assumes the caller
// gates the side port while an instruction is in flight.
module ptr_ld_regfile
    import ptr_ld_pkg::*;
#(
    parameter int REG_COUNT  = 32,
    parameter int DATA_W     = 8,
    parameter int PTR_LO_IDX = 26,
    parameter int PTR_HI_IDX = 27
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_we_i,
    input  logic [IDX_W-1:0]      ext_idx_i,
    input  logic [DATA_W-1:0]     ext_data_i,
    input  logic                  ptr_we_i,
    input  logic [2*DATA_W-1:0]   ptr_data_i,
    input  logic                  dst_we_i,
    input  logic [IDX_W-1:0]      dst_idx_i,
    input  logic [DATA_W-1:0]     dst_data_i,
    input  logic [IDX_W-1:0]      rd_idx_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [2*DATA_W-1:0]   ptr_o
);

    logic [DATA_W-1:0] regs [REG_COUNT];

    // Update every entry with the prioritised write sources.
    always_ff @(posedge clk) begin
        for (int i = 0; i < REG_COUNT; i++) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (dst_we_i && (dst_idx_i == IDX_W'(i))) begin
                regs[i] <= dst_data_i;
            end else if (ptr_we_i && (i == PTR_HI_IDX)) begin
                regs[i] <= ptr_data_i[2*DATA_W-1:DATA_W];
            end else if (ptr_we_i && (i == PTR_LO_IDX)) begin
                regs[i] <= ptr_data_i[DATA_W-1:0];
            end else if (ext_we_i && (ext_idx_i == IDX_W'(i))) begin
                regs[i] <= ext_data_i;
            end
        end
    end

    // Combinational read port and pointer pair view.
    always_comb begin
        rd_data_o = regs[rd_idx_i];
        ptr_o     = {regs[PTR_HI_IDX], regs[PTR_LO_IDX]};
    end

endmodule

// File: rtl/ptr_load_unit.sv
// ptr_load_unit: indirect pointer load unit. Accepts a load word when idle
// or in the last cycle, reads data space in the last cycle and commits the
// loaded byte and pointer update at the edge that closes it. Assumes a read
// port whose data is valid in the strobe cycle, sampled at the clock edge.
module ptr_load_unit
    import ptr_ld_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter int                REG_COUNT  = 32,
    parameter int                PTR_LO_IDX = 26,
    parameter int                PTR_HI_IDX = 27,
    parameter logic [ADDR_W-1:0] SRAM_LO    = 16'h0100,
    parameter logic [ADDR_W-1:0] SRAM_HI    = 16'h40FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic              compact_mode,
    output logic              busy,
    output logic              done,
    output logic              illegal_combo,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              rf_wr_en,
    input  logic [IDX_W-1:0]  rf_wr_idx,
    input  logic [DATA_W-1:0] rf_wr_data,
    input  logic [IDX_W-1:0]  rf_rd_idx,
    output logic [DATA_W-1:0] rf_rd_data
);

    ld_decode_t        dec;
    logic              start;
    logic              active;
    ld_mode_e          mode_q;
    logic [IDX_W-1:0]  dst_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] next_ptr;
    logic              sram_hit;
    logic              dst_in_pair;
    logic              ext_we;

    ptr_ld_decode u_decode (
        .word_i (instr_word),
        .dec_o  (dec)
    );

    // Accept a recognised word only while not busy.
    always_comb start = instr_valid && dec.hit && !busy;

    ptr_ld_seq #(
        .MAX_CYC (4)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dec_i      (dec),
        .compact_i  (compact_mode),
        .sram_hit_i (sram_hit),
        .active_o   (active),
        .busy_o     (busy),
        .done_o     (done),
        .mode_o     (mode_q),
        .dst_o      (dst_q)
    );

    ptr_ld_addr #(
        .ADDR_W  (ADDR_W),
        .SRAM_LO (SRAM_LO),
        .SRAM_HI (SRAM_HI)
    ) u_addr (
        .ptr_i      (ptr_q),
        .mode_i     (mode_q),
        .eff_addr_o (eff_addr),
        .next_ptr_o (next_ptr),
        .sram_hit_o (sram_hit)
    );

    // Flag a destination that collides with a pointer byte being updated.
    always_comb begin
        dst_in_pair   = (dst_q == IDX_W'(PTR_LO_IDX)) || (dst_q == IDX_W'(PTR_HI_IDX));
        illegal_combo = active && dst_in_pair && (mode_q != MODE_PLAIN);
    end

    // Read strobe and address for the data-space port.
    always_comb begin
        mem_rd_en = done;
        mem_addr  = eff_addr;
    end

    // Side-port writes are blocked while an instruction is in flight.
    always_comb ext_we = rf_wr_en && !active;

    ptr_ld_regfile #(
        .REG_COUNT  (REG_COUNT),
        .DATA_W     (DATA_W),
        .PTR_LO_IDX (PTR_LO_IDX),
        .PTR_HI_IDX (PTR_HI_IDX)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_we_i   (ext_we),
        .ext_idx_i  (rf_wr_idx),
        .ext_data_i (rf_wr_data),
        .ptr_we_i   (done && (mode_q != MODE_PLAIN)),
        .ptr_data_i (next_ptr),
        .dst_we_i   (done),
        .dst_idx_i  (dst_q),
        .dst_data_i (mem_rd_data),
        .rd_idx_i   (rf_rd_idx),
        .rd_data_o  (rf_rd_data),
        .ptr_o      (ptr_q)
    );

endmodule

// File: rtl/ptr_load_unit_chk.sv
// ptr_load_unit_chk: temporal checks on the load unit, bound to every
// instance of the top module. Observes ports and the pointer pair.
module ptr_load_unit_chk
    import ptr_ld_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PTR_LO_IDX = 26,
    parameter int PTR_HI_IDX = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal_combo,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] ptr_q,
    input ld_mode_e          mode_q,
    input logic [IDX_W-1:0]  dst_q
);

    logic in_pair;

    // Destination index falls on either pointer byte.
    always_comb in_pair = (dst_q == IDX_W'(PTR_LO_IDX)) || (dst_q == IDX_W'(PTR_HI_IDX));

    p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_read_only_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_rd_en);

    p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q));

    p_plain_keeps_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_PLAIN && !in_pair) |=> $stable(ptr_q));

    p_postinc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_POSTINC && !in_pair) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

    p_predec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_PREDEC && !in_pair) |=> (ptr_q == ADDR_W'($past(ptr_q) - 1'b1)));

    p_flag_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_combo |-> (busy || done));

endmodule

bind ptr_load_unit ptr_load_unit_chk #(
    .ADDR_W     (ADDR_W),
    .PTR_LO_IDX (PTR_LO_IDX),
    .PTR_HI_IDX (PTR_HI_IDX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .illegal_combo (illegal_combo),
    .mem_rd_en     (mem_rd_en),
    .ptr_q         (ptr_q),
    .mode_q        (mode_q),
    .dst_q         (dst_q)
);

// File: tb/ptr_load_unit_bench.sv
// Scoreboard bench: the driver computes expected results from a register
// shadow and queues them; a monitor pops one item per done cycle.
module ptr_load_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        compact_mode = 1'b0;
    logic        busy, done, illegal_combo, mem_rd_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rd_data;
    logic        rf_wr_en = 1'b0;
    logic [4:0]  rf_wr_idx = '0;
    logic [7:0]  rf_wr_data = '0;
    logic [4:0]  rf_rd_idx = '0;
    logic [7:0]  rf_rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    cyc;
        int    addr;
        bit    ill;
        string req;
    } exp_t;

    exp_t      sb[$];
    logic [7:0] sh [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_load_unit u_ptr_load_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .compact_mode(compact_mode), .busy(busy), .done(done), .illegal_combo(illegal_combo),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
    );

    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rd_data = memf(mem_addr);

    function automatic logic [15:0] mk(int mode, int dst);
        logic [3:0] nib;
        nib = (mode == 0) ? 4'b1100 : (mode == 1) ? 4'b1101 : 4'b1110;
        return {7'b1001000, 5'(dst), nib};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic rd(int idx, output logic [7:0] v);
        rf_rd_idx = 5'(idx);
        #1;
        v = rf_rd_data;
    endtask

    task automatic check_regs(string req);
        logic [7:0] v;
        int bad = 0;
        for (int i = 0; i < 32; i++) begin
            rd(i, v);
            if (v !== sh[i]) begin
                bad++;
                $display("FAIL %s reg r%0d: actual %0h expected %0h", req, i, v, sh[i]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic wr(int idx, logic [7:0] val);
        rf_wr_en = 1'b1; rf_wr_idx = 5'(idx); rf_wr_data = val;
        @(posedge clk); @(negedge clk);
        rf_wr_en = 1'b0;
        sh[idx] = val;
    endtask

    task automatic set_ptr(logic [15:0] p);
        wr(26, p[7:0]);
        wr(27, p[15:8]);
    endtask

    // Driver: push expectation, update shadow, present the word for one edge.
    task automatic issue(int mode, int dst, bit cmp, string req);
        logic [15:0] p, eff, np;
        exp_t e;
        int n;
        p   = {sh[27], sh[26]};
        eff = (mode == 2) ? p - 16'd1 : p;
        np  = (mode == 1) ? p + 16'd1 : (mode == 2) ? p - 16'd1 : p;
        if (!cmp) n = mode + 1;
        else      n = ((mode == 2) ? 2 : 1) + ((eff >= 16'h0100 && eff <= 16'h40FF) ? 1 : 0);
        e.cyc = n; e.addr = eff; e.ill = (dst == 26 || dst == 27) && mode != 0; e.req = req;
        sb.push_back(e);
        if (mode != 0) begin sh[27] = np[15:8]; sh[26] = np[7:0]; end
        sh[dst] = memf(eff);
        instr_valid = 1'b1; instr_word = mk(mode, dst); compact_mode = cmp;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(int mode, int dst, bit cmp, string req);
        issue(mode, dst, cmp, req);
        wait_done();
        @(negedge clk);
        check_regs(req);
    endtask

    // Monitor: count in-flight cycles and compare at each done against the queue head.
    initial begin
        int cnt = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cnt = 0;
            end else begin
                if (busy || done) cnt++;
                if (busy) check(!mem_rd_en, "R7", "strobe before last cycle", int'(mem_rd_en), 0);
                if (done) begin
                    if (sb.size() == 0) begin
                        check(0, "R10", "unexpected done", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check(cnt == e.cyc, e.req, "cycle count", cnt, e.cyc);
                        check(mem_rd_en && mem_addr == e.addr[15:0], "R7", "read address", int'(mem_addr), e.addr);
                        check(illegal_combo == e.ill, "R9", "illegal flag", int'(illegal_combo), int'(e.ill));
                    end
                    cnt = 0;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 32; i++) sh[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check(!busy && !done && !illegal_combo && !mem_rd_en, "R12", "handshake after reset",
              {busy, done, illegal_combo, mem_rd_en}, 0);
        check_regs("R12");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: classic profile, each form
        set_ptr(16'h0060);
        run(0, 0, 0, "R2");
        run(1, 1, 0, "R3");
        wr(26, 8'h63);
        run(0, 2, 0, "R5");
        run(2, 3, 0, "R4");

        // R6: compact profile outside and inside the SRAM window
        run(0, 4, 1, "R6");
        run(1, 5, 1, "R6");
        run(2, 6, 1, "R6");
        set_ptr(16'h0200);
        run(0, 7, 1, "R6");
        run(1, 8, 1, "R6");
        set_ptr(16'h0100);
        run(2, 9, 1, "R6");
        set_ptr(16'h0101);
        run(2, 10, 1, "R6");
        set_ptr(16'h40FF);
        run(1, 11, 1, "R6");

        // R3 R4: carry, borrow and 16-bit wrap
        set_ptr(16'h12FF);
        run(1, 12, 0, "R3");
        set_ptr(16'hFFFF);
        run(1, 13, 0, "R3");
        run(2, 14, 0, "R4");
        run(2, 15, 1, "R4");

        // R9: destination collides with the pointer pair
        set_ptr(16'h12FF);
        run(1, 26, 0, "R9");
        set_ptr(16'h0500);
        run(2, 27, 1, "R9");
        set_ptr(16'h0077);
        run(0, 26, 0, "R9");

        // R1: words outside the pattern are ignored
        instr_valid = 1'b1; instr_word = 16'h900F;
        @(posedge clk); @(negedge clk);
        check(!busy && !done, "R1", "bad nibble accepted", {busy, done}, 0);
        instr_word = 16'h920C;
        @(posedge clk); @(negedge clk);
        check(!busy && !done, "R1", "bad opcode accepted", {busy, done}, 0);
        instr_word = 16'h900B;
        @(posedge clk); @(negedge clk);
        check(!busy && !done, "R1", "bad nibble accepted", {busy, done}, 0);
        instr_valid = 1'b0;
        @(negedge clk);
        check_regs("R1");

        // R8 R10 R11: word and side write offered while busy, early read of dest
        set_ptr(16'h0300);
        v = sh[16];
        begin
            logic [7:0] old_lo;
            old_lo = sh[26];
            issue(2, 16, 0, "R10");
            rd(16, v);
            check(v == 8'h00, "R8", "dest written early", v, 8'h00);
            rd(26, v);
            check(v == old_lo, "R8", "pointer moved early", v, old_lo);
            instr_valid = 1'b1; instr_word = mk(0, 17);
            rf_wr_en = 1'b1; rf_wr_idx = 5'd18; rf_wr_data = 8'hAA;
            @(posedge clk); @(negedge clk);
            instr_valid = 1'b0; rf_wr_en = 1'b0;
            check(busy, "R10", "busy in cycle two", int'(busy), 1);
            wait_done();
            @(negedge clk);
            check_regs("R11");
        end

        // R10: back-to-back issue in the done cycle
        set_ptr(16'h0030);
        issue(1, 19, 1, "R10");
        check(done, "R10", "single-cycle done", int'(done), 1);
        issue(1, 20, 1, "R10");
        wait_done();
        @(negedge clk);
        check_regs("R10");
        issue(0, 21, 0, "R10");
        issue(2, 22, 0, "R10");
        wait_done();
        @(negedge clk);
        check_regs("R10");

        // R11: side write applied when idle
        wr(23, 8'h3C);
        check_regs("R11");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7", "pending expectations", sb.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule